// File: doc/BRIEF.md
# I2C Bus Condition Sequencer

This block is the part of an I2C controller that owns the bus conditions. A small control register holds an enable bit, a START request, a STOP request and an acknowledge-policy bit. From these, the block emits START, repeated START and STOP waveforms on SCL and SDA through active-low open-drain enables. It tracks whether the bus is occupied by decoding START and STOP conditions on the live lines. When a request has been carried out, hardware clears the request bit.

A START request made while another master holds the bus is kept until a STOP is seen. The block then waits a bus-free gap measured in half-period ticks, and only after that does it drive its own START. A STOP request from the slave side drives nothing onto the lines. It only resets the slave state, which gives software a way out of a stuck transfer. Each completed condition, internal ones included, raises a one-cycle strobe for the byte engine. Byte shifting and address decoding are left to neighbouring blocks. The address decoder reports a match through `slv_match`, and the byte engine reports a finished byte through `xfer_done`.

Top module: `i2c_cond_seq`

## Requirements
- R1: After reset, both line enables read 1 (released). `od_en`, `bus_busy`, `master`, `addressed`, `cond_done` and all four register bits read 0.
- R2: While the enable bit is 0, the STOP request bit reads 0. A write of `cfg_sto`=1 together with `cfg_en`=0 leaves it at 0.
- R3: On a START request with the bus free and the block not master, `master` rises. SDA is pulled low while SCL stays released for PHASE_TICKS ticks, then SCL is pulled low as well. The START request bit then clears.
- R4: `bus_busy` goes to 1 when SDA falls while SCL is high. It goes to 0 when SDA rises while SCL is high, and it is 0 whenever the block is disabled.
- R5: In master mode, a START request becomes a repeated START only after a `xfer_done` pulse. Before that pulse, the request stays pending and both lines stay held low. The repeated START releases SDA, then SCL, and then forms a START.
- R6: A STOP request in master mode drives SDA low and SCL low, releases SCL, then releases SDA. The STOP request bit and `master` clear in the cycle the STOP is decoded on the bus.
- R7: STOP and START requested together in master mode give a STOP on the bus. After GAP_TICKS ticks, a START follows, and the block ends in master mode with both request bits clear.
- R8: A START request while `bus_busy` is 1 sets `master` but drives nothing until a STOP appears on the bus. After the bus-free gap, the block issues its START.
- R9: A STOP request outside master mode drives neither line. It clears the STOP request bit and `addressed`, and `bus_busy` is left as it was.
- R10: STOP and START requested together outside master mode clear both request bits with no bus activity. `master` stays 0.
- R11: `cond_done` is high for exactly one cycle after each finished START, repeated START, bus STOP or internal STOP.
- R12: Writing `cfg_en`=0 releases both lines, clears `master`, `addressed` and `bus_busy`, and drops `od_en`. `od_en` follows the enable bit.
- R13: A write (`cfg_wr`=1) loads the enable and acknowledge bits from `cfg_en` and `cfg_ack`. It sets the START or STOP request only where `cfg_sta` or `cfg_sto` is 1, and the stored values read back on the `stat_*` outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_en | input | 1 | Enable value written |
| cfg_sta | input | 1 | 1 sets the START request |
| cfg_sto | input | 1 | 1 sets the STOP request |
| cfg_ack | input | 1 | Acknowledge-policy value written |
| stat_en | output | 1 | Stored enable bit |
| stat_sta | output | 1 | Pending START request |
| stat_sto | output | 1 | Pending STOP request |
| stat_ack | output | 1 | Stored acknowledge-policy bit |
| half_tick | input | 1 | One-cycle pulse per SCL half period |
| xfer_done | input | 1 | Byte engine finished a byte |
| slv_match | input | 1 | Address decoder matched this slave |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| scl_oe_n | output | 1 | SCL pull-down, 0 pulls low |
| sda_oe_n | output | 1 | SDA pull-down, 0 pulls low |
| od_en | output | 1 | Pins switched to open-drain function |
| master | output | 1 | Master-mode flag |
| addressed | output | 1 | Addressed-slave flag |
| bus_busy | output | 1 | Bus occupied |
| cond_done | output | 1 | Condition finished strobe |

## Verification
Two functions can meet in one transition: completing a bus STOP and starting the bus-free gap for a START that is still pending. The bench provokes this by writing both requests in one write while in master mode. It also asks for START while another master owns the bus, and a modelled external master releases it later. A scoreboard queue holds the conditions expected on the wired-AND lines, and a monitor pops one entry for every START or STOP it decodes there. A missing STOP before the START, a START inside the gap, or any bus activity during a slave-side recovery therefore shows up as a mismatch.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT_FREE,
    ST_GAP,
    ST_S_SDA,
    ST_HOLD,
    ST_R_SDA,
    ST_R_SCL,
    ST_P_LOW,
    ST_P_SCL,
    ST_P_SDA
  } cond_st_e;

  // {scl released, sda released} for a state
  function automatic logic [1:0] line_rel(cond_st_e st);
    case (st)
      ST_S_SDA: line_rel = 2'b10;
      ST_HOLD:  line_rel = 2'b00;
      ST_R_SDA: line_rel = 2'b01;
      ST_P_LOW: line_rel = 2'b00;
      ST_P_SCL: line_rel = 2'b10;
      default:  line_rel = 2'b11;
    endcase
  endfunction

endpackage

// File: rtl/i2c_ctrl_reg.sv
module i2c_ctrl_reg (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic w_en,
  input  logic w_sta,
  input  logic w_sto,
  input  logic w_ack,
  input  logic clr_sta,
  input  logic clr_sto,
  output logic en_q,
  output logic sta_q,
  output logic sto_q,
  output logic ack_q
);
  logic en_next;
  assign en_next = wr ? w_en : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      sta_q <= 1'b0;
      sto_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      en_q  <= en_next;
      if (wr) ack_q <= w_ack;
      sta_q <= (sta_q & ~clr_sta) | (wr & w_sta);
      sto_q <= en_next & ((sto_q & ~clr_sto) | (wr & w_sto));
    end
  end
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic scl,
  input  logic sda,
  output logic stop_det,
  output logic busy
);
  logic scl_p, sda_p, start_det;

  assign start_det = scl_p & scl & sda_p & ~sda;
  assign stop_det  = scl_p & scl & ~sda_p & sda;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
      busy  <= 1'b0;
    end else begin
      scl_p <= scl;
      sda_p <= sda;
      if (!en)            busy <= 1'b0;
      else if (start_det) busy <= 1'b1;
      else if (stop_det)  busy <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_cond_fsm.sv
module i2c_cond_fsm
  import i2c_cond_pkg::*;
#(
  parameter int PHASE_TICKS = 1,
  parameter int GAP_TICKS   = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic half_tick,
  input  logic sta_req,
  input  logic sto_req,
  input  logic busy,
  input  logic stop_det,
  input  logic xfer_done,
  input  logic slv_match,
  output logic clr_sta,
  output logic clr_sto,
  output logic scl_oe_n,
  output logic sda_oe_n,
  output logic master,
  output logic addressed,
  output logic cond_done
);
  localparam int TMAX = (PHASE_TICKS > GAP_TICKS) ? PHASE_TICKS : GAP_TICKS;
  localparam int CW   = $clog2(TMAX + 1);

  cond_st_e state, state_d;
  logic [CW-1:0] tcnt, lim_m1;
  logic phase_end, master_d, addr_d, data_seen, data_d, done_d;

  assign lim_m1    = (state == ST_GAP) ? CW'(GAP_TICKS - 1) : CW'(PHASE_TICKS - 1);
  assign phase_end = half_tick && (tcnt == lim_m1);

  always_comb begin
    state_d  = state;
    clr_sta  = 1'b0;
    clr_sto  = 1'b0;
    done_d   = 1'b0;
    master_d = master;
    data_d   = data_seen;
    addr_d   = stop_det ? 1'b0 : ((slv_match && !master) ? 1'b1 : addressed);
    case (state)
      ST_IDLE: begin
        if (sto_req) begin
          clr_sto = 1'b1;
          clr_sta = sta_req;
          addr_d  = 1'b0;
          done_d  = 1'b1;
        end else if (sta_req) begin
          master_d = 1'b1;
          state_d  = busy ? ST_WAIT_FREE : ST_S_SDA;
        end
      end
      ST_WAIT_FREE, ST_GAP: begin
        if (sto_req) begin
          clr_sto  = 1'b1;
          clr_sta  = sta_req;
          master_d = 1'b0;
          done_d   = 1'b1;
          state_d  = ST_IDLE;
        end else if (state == ST_WAIT_FREE) begin
          if (!busy) state_d = ST_GAP;
        end else if (busy) begin
          state_d = ST_WAIT_FREE;
        end else if (phase_end) begin
          state_d = ST_S_SDA;
        end
      end
      ST_S_SDA: if (phase_end) begin
        state_d = ST_HOLD;
        clr_sta = 1'b1;
        done_d  = 1'b1;
        data_d  = 1'b0;
      end
      ST_HOLD: begin
        if (xfer_done) data_d = 1'b1;
        if (sto_req) state_d = ST_P_LOW;
        else if (sta_req && data_seen) state_d = ST_R_SDA;
      end
      ST_R_SDA: if (phase_end) state_d = ST_R_SCL;
      ST_R_SCL: if (phase_end) state_d = ST_S_SDA;
      ST_P_LOW: if (phase_end) state_d = ST_P_SCL;
      ST_P_SCL: if (phase_end) state_d = ST_P_SDA;
      ST_P_SDA: if (stop_det) begin
        clr_sto = 1'b1;
        done_d  = 1'b1;
        if (sta_req) begin
          state_d = ST_GAP;
        end else begin
          state_d  = ST_IDLE;
          master_d = 1'b0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state     <= ST_IDLE;
      tcnt      <= '0;
      master    <= 1'b0;
      addressed <= 1'b0;
      data_seen <= 1'b0;
      scl_oe_n  <= 1'b1;
      sda_oe_n  <= 1'b1;
      cond_done <= 1'b0;
    end else begin
      state     <= state_d;
      tcnt      <= (state_d != state) ? '0 : (half_tick ? tcnt + CW'(1) : tcnt);
      master    <= master_d;
      addressed <= addr_d;
      data_seen <= data_d;
      {scl_oe_n, sda_oe_n} <= line_rel(state_d);
      cond_done <= done_d;
    end
  end
endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq #(
  parameter int PHASE_TICKS = 1,
  parameter int GAP_TICKS   = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_wr,
  input  logic cfg_en,
  input  logic cfg_sta,
  input  logic cfg_sto,
  input  logic cfg_ack,
  output logic stat_en,
  output logic stat_sta,
  output logic stat_sto,
  output logic stat_ack,
  input  logic half_tick,
  input  logic xfer_done,
  input  logic slv_match,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_oe_n,
  output logic sda_oe_n,
  output logic od_en,
  output logic master,
  output logic addressed,
  output logic bus_busy,
  output logic cond_done
);
  logic clr_sta, clr_sto, stop_det;

  i2c_ctrl_reg u_reg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .w_en(cfg_en), .w_sta(cfg_sta),
    .w_sto(cfg_sto), .w_ack(cfg_ack), .clr_sta(clr_sta), .clr_sto(clr_sto),
    .en_q(stat_en), .sta_q(stat_sta), .sto_q(stat_sto), .ack_q(stat_ack)
  );

  i2c_bus_watch u_watch (
    .clk(clk), .rst(rst), .en(stat_en), .scl(scl_in), .sda(sda_in),
    .stop_det(stop_det), .busy(bus_busy)
  );

  i2c_cond_fsm #(.PHASE_TICKS(PHASE_TICKS), .GAP_TICKS(GAP_TICKS)) u_fsm (
    .clk(clk), .rst(rst), .en(stat_en), .half_tick(half_tick),
    .sta_req(stat_sta), .sto_req(stat_sto), .busy(bus_busy),
    .stop_det(stop_det), .xfer_done(xfer_done), .slv_match(slv_match),
    .clr_sta(clr_sta), .clr_sto(clr_sto), .scl_oe_n(scl_oe_n),
    .sda_oe_n(sda_oe_n), .master(master), .addressed(addressed),
    .cond_done(cond_done)
  );

  assign od_en = stat_en;
endmodule

// File: rtl/i2c_cond_seq_chk.sv
module i2c_cond_seq_chk (
  input logic clk,
  input logic rst,
  input logic stat_en,
  input logic stat_sto,
  input logic scl_oe_n,
  input logic sda_oe_n,
  input logic od_en,
  input logic master,
  input logic bus_busy,
  input logic cond_done
);
  // R2
  sto_off_chk: assert property (@(posedge clk) disable iff (rst)
    !stat_en |-> !stat_sto);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cond_done |=> !cond_done);

  // R9
  slave_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !master |-> (scl_oe_n && sda_oe_n));

  // R4
  busy_off_chk: assert property (@(posedge clk) disable iff (rst)
    !stat_en |=> !bus_busy);

  // R12
  od_release_chk: assert property (@(posedge clk) disable iff (rst)
    !od_en |=> (scl_oe_n && sda_oe_n));
endmodule

bind i2c_cond_seq i2c_cond_seq_chk chk_i (
  .clk(clk), .rst(rst), .stat_en(stat_en), .stat_sto(stat_sto),
  .scl_oe_n(scl_oe_n), .sda_oe_n(sda_oe_n), .od_en(od_en),
  .master(master), .bus_busy(bus_busy), .cond_done(cond_done)
);

// File: tb/i2c_cond_seq_tb_top.sv
module i2c_cond_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 0, cfg_en = 0, cfg_sta = 0, cfg_sto = 0, cfg_ack = 0;
  logic xfer_done = 0, slv_match = 0;
  logic half_tick = 0;
  logic ext_scl_n = 1, ext_sda_n = 1;
  logic stat_en, stat_sta, stat_sto, stat_ack;
  logic scl_oe_n, sda_oe_n, od_en, master, addressed, bus_busy, cond_done;
  logic bus_scl, bus_sda;
  logic pscl = 1, psda = 1, pdone = 0;
  logic [2:0] tick_cnt = 0;
  logic [7:0] exp_q[$];
  int checks = 0, fails = 0, done_cnt = 0, dbl_done = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign bus_scl = scl_oe_n & ext_scl_n;
  assign bus_sda = sda_oe_n & ext_sda_n;

  i2c_cond_seq dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_sta(cfg_sta),
    .cfg_sto(cfg_sto), .cfg_ack(cfg_ack), .stat_en(stat_en), .stat_sta(stat_sta),
    .stat_sto(stat_sto), .stat_ack(stat_ack), .half_tick(half_tick),
    .xfer_done(xfer_done), .slv_match(slv_match), .scl_in(bus_scl),
    .sda_in(bus_sda), .scl_oe_n(scl_oe_n), .sda_oe_n(sda_oe_n), .od_en(od_en),
    .master(master), .addressed(addressed), .bus_busy(bus_busy),
    .cond_done(cond_done)
  );

  always @(posedge clk) begin
    tick_cnt  <= rst ? 3'd0 : tick_cnt + 3'd1;
    half_tick <= !rst && (tick_cnt == 3'd7);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: decode conditions on wired lines and compare with scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_scl && pscl && psda && !bus_sda) begin
        if (exp_q.size() == 0) check(0, "R9 unexpected START", 83, 0);
        else check(exp_q.pop_front() == 8'd83, "R3 bus condition START", 83, 80);
      end
      if (bus_scl && pscl && !psda && bus_sda) begin
        if (exp_q.size() == 0) check(0, "R9 unexpected STOP", 80, 0);
        else check(exp_q.pop_front() == 8'd80, "R6 bus condition STOP", 80, 83);
      end
      if (cond_done) done_cnt++;
      if (cond_done && pdone) dbl_done++;
    end
    pscl  <= bus_scl;
    psda  <= bus_sda;
    pdone <= cond_done;
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic e, input logic sa, input logic so, input logic a);
    @(negedge clk);
    cfg_en = e; cfg_sta = sa; cfg_sto = so; cfg_ack = a; cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0; cfg_sta = 0; cfg_sto = 0;
  endtask

  task automatic wait_done(input int n, input string req);
    for (int i = 0; i < 2000; i++) begin
      if (done_cnt >= n) break;
      @(negedge clk);
    end
    check(done_cnt >= n, req, done_cnt, n);
    cycles(2);
  endtask

  task automatic ext_start();
    exp_q.push_back(8'd83);
    @(negedge clk); ext_sda_n = 0;
    cycles(8); ext_scl_n = 0;
    cycles(4);
  endtask

  task automatic ext_stop();
    exp_q.push_back(8'd80);
    @(negedge clk); ext_sda_n = 0;
    cycles(4); ext_scl_n = 1;
    cycles(8); ext_sda_n = 1;
    cycles(4);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  initial begin
    cycles(4);
    rst = 0;
    cycles(2);
    // R1 reset state
    check(scl_oe_n && sda_oe_n, "R1 lines released", {scl_oe_n, sda_oe_n}, 3);
    check(!od_en && !bus_busy && !master && !addressed && !cond_done, "R1 flags",
          {od_en, bus_busy, master, addressed, cond_done}, 0);
    check({stat_en, stat_sta, stat_sto, stat_ack} == 4'b0, "R1 register",
          {stat_en, stat_sta, stat_sto, stat_ack}, 0);

    // R2 STOP request ignored while disabled
    wr(0, 0, 1, 0);
    check(!stat_sto, "R2 sto held at 0", stat_sto, 0);

    // R13 enable and ack load
    wr(1, 0, 0, 1);
    check(stat_en && stat_ack && od_en, "R13 en/ack readback", {stat_en, stat_ack, od_en}, 7);

    // R3 START on free bus
    exp_q.push_back(8'd83);
    wr(1, 1, 0, 1);
    wait_done(1, "R3 start done");
    check(master && !stat_sta && !scl_oe_n, "R3 master, sta clear, SCL held",
          {master, stat_sta, scl_oe_n}, 4);
    check(bus_busy, "R4 busy after START", bus_busy, 1);

    // R5 repeated START waits for a finished byte
    wr(1, 1, 0, 1);
    cycles(40);
    check(stat_sta && !scl_oe_n && !sda_oe_n, "R5 request pending, lines held",
          {stat_sta, scl_oe_n, sda_oe_n}, 4);
    exp_q.push_back(8'd83);
    pulse(xfer_done);
    wait_done(2, "R5 repeated start done");
    check(!stat_sta && master && bus_busy, "R5 after repeated START",
          {stat_sta, master, bus_busy}, 3);

    // R6 STOP in master mode
    exp_q.push_back(8'd80);
    wr(1, 0, 1, 1);
    wait_done(3, "R6 stop done");
    check(!stat_sto && !master && !bus_busy && scl_oe_n && sda_oe_n, "R6 after STOP",
          {stat_sto, master, bus_busy, scl_oe_n, sda_oe_n}, 3);

    // R7 combined STOP+START in master mode
    exp_q.push_back(8'd83);
    wr(1, 1, 0, 1);
    wait_done(4, "R7 initial start");
    exp_q.push_back(8'd80);
    exp_q.push_back(8'd83);
    wr(1, 1, 1, 1);
    wait_done(6, "R7 stop then start");
    check(master && !stat_sta && !stat_sto && bus_busy, "R7 master after combined",
          {master, stat_sta, stat_sto, bus_busy}, 9);
    check(exp_q.size() == 0, "R7 both conditions seen", exp_q.size(), 0);
    exp_q.push_back(8'd80);
    wr(1, 0, 1, 1);
    wait_done(7, "R6 release after R7");

    // R8 START request while another master owns the bus
    ext_start();
    check(bus_busy, "R4 busy from external START", bus_busy, 1);
    wr(1, 1, 0, 1);
    cycles(50);
    check(master && stat_sta && sda_oe_n && scl_oe_n, "R8 waiting, nothing driven",
          {master, stat_sta, sda_oe_n, scl_oe_n}, 15);
    ext_stop();
    check(!bus_busy, "R4 free after external STOP", bus_busy, 0);
    exp_q.push_back(8'd83);
    wait_done(8, "R8 start after bus free");
    check(!stat_sta && master, "R8 own START issued", {stat_sta, master}, 1);
    exp_q.push_back(8'd80);
    wr(1, 0, 1, 1);
    wait_done(9, "R8 stop");

    // R9 slave recovery
    ext_start();
    pulse(slv_match);
    cycles(1);
    check(addressed, "R9 addressed set", addressed, 1);
    wr(1, 0, 1, 1);
    wait_done(10, "R9 internal stop done");
    check(!stat_sto && !addressed && !master && scl_oe_n && sda_oe_n && bus_busy,
          "R9 recovery without bus activity",
          {stat_sto, addressed, master, scl_oe_n, sda_oe_n, bus_busy}, 7);

    // R10 combined request in slave mode
    pulse(slv_match);
    wr(1, 1, 1, 1);
    wait_done(11, "R10 internal stop done");
    check(!stat_sta && !stat_sto && !master && !addressed, "R10 both cleared",
          {stat_sta, stat_sto, master, addressed}, 0);
    ext_stop();

    // R12 disable while master
    exp_q.push_back(8'd83);
    wr(1, 1, 0, 1);
    wait_done(12, "R12 start before disable");
    wr(0, 0, 0, 1);
    cycles(2);
    check(scl_oe_n && sda_oe_n && !master && !bus_busy && !od_en && !stat_sto,
          "R12 disabled state",
          {scl_oe_n, sda_oe_n, master, bus_busy, od_en, stat_sto}, 48);

    // R11 one pulse per condition
    check(done_cnt == 12, "R11 done pulse count", done_cnt, 12);
    check(dbl_done == 0, "R11 pulses one cycle wide", dbl_done, 0);
    check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule